// File: doc/BRIEF.md
# Selectable ADC Output Test Pattern Generator

This block sits between a converter's data path and its output serializer. It can replace the real sample word with a known test pattern, so that a receiver can check its capture and timing. A 4-bit mode input selects what is sent. The choices are real data, three fixed levels, four other fixed single words, three patterns that alternate between two words (a checkerboard, an all-ones/all-zeros toggle and a pair of user words), and two pseudo-random bit sequences.

The block produces one output word per sample strobe, together with a one-cycle valid flag. It works in a long (14-bit) or a short (12-bit) word form. A format input selects two's-complement output. That input only acts on the three level patterns and the two pseudo-random patterns; every other pattern is sent exactly as defined.

Top module: `adc_test_pattern_gen`

## Requirements
- R1: `pat_valid` is high in exactly the cycle after each cycle in which `sample_stb` is high. `pat_word` changes only in the cycle after a strobe.
- R2: Mode 0000 and the unused codes 1101, 1110 and 1111 pass `adc_data` through: the whole word in long form, or `adc_data[13:2]` in bits 11:0 in short form.
- R3: Level modes give these words in long and short form: 0001 = 0x2000 / 0x800, 0010 = 0x3FFF / 0xFFF, 0011 = 0x0000 / 0x000.
- R4: With `twos_comp` = 1, modes 0001, 0010, 0011, 0101 and 0110 invert the word's MSB. That is bit 13 in long form and for both PN modes, and bit 11 for short-form levels. `twos_comp` has no effect on any other mode.
- R5: Mode 0100 alternates 0x2AAA and 0x1555 (short: 0xAAA and 0x555). Mode 0111 alternates 0x3FFF and 0x0000 (short: 0xFFF and 0x000). Both start with the first word.
- R6: Single-word modes give these long / short words: 1001 = 0x2AAA / 0xAAA, 1010 = 0x007F / 0x03F, 1011 = 0x2000 / 0x800, 1100 = 0x2867 / 0xA33.
- R7: Mode 1000 alternates two user words, starting with word one. Word one is `{user1_hi,user1_lo}` and word two is `{user2_hi,user2_lo}`. Bits 15:2 of that pair form the long word, and bits 15:4 form the short word.
- R8: Mode 0110 sends bit sequence s[n+9] = s[n] xor s[n+4], with s[0..8] all ones when the mode is entered. Each strobe sends the next 14 bits, earliest bit in bit 13. The first word is 0x3FE0.
- R9: Mode 0101 sends s[n+23] = s[n] xor s[n+5], with s[0..22] all ones when the mode is entered. The word packing is the same as in R8, so the first word is 0x3FFF.
- R10: The PN modes always give a full 14-bit word, whatever `short_word` is.
- R11: Mode is compared with its value at the previous strobe (0000 after reset). When it differs, the two-word patterns restart at word one and the PN sequences restart from their seed.
- R12: In short form, every non-PN mode gives bits 13:12 = 0.
- R13: In reset, `pat_word` is 0 and `pat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | One output word is produced per high cycle |
| mode | input | 4 | Pattern select code |
| twos_comp | input | 1 | 1 selects two's-complement format for the patterns that honour it |
| short_word | input | 1 | 1 selects 12-bit words, right-aligned |
| adc_data | input | 14 | Real converter sample |
| user1_hi | input | 8 | User word one, upper byte |
| user1_lo | input | 8 | User word one, lower byte |
| user2_hi | input | 8 | User word two, upper byte |
| user2_lo | input | 8 | User word two, lower byte |
| pat_word | output | 14 | Output word |
| pat_valid | output | 1 | High for one cycle with each new word |

## Verification
Every result is due exactly one clock after the strobe that requests it: the word and the valid flag are both registered once, and nothing else lies in the path. The bench model steps on the same rising edge, using the inputs that were driven at the previous falling edge. The bench compares word and flag at the following falling edge, so each comparison falls in the first cycle the result can appear. Directed checks follow the same rule: drive at a falling edge, drop the strobe at the next falling edge, and read the output there.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int WORD_W  = 14;
  localparam int SHORT_W = 12;
  localparam int UREG_W  = 8;
  localparam int MODE_W  = 4;

  typedef enum logic [MODE_W-1:0] {
    PM_OFF      = 4'd0,
    PM_MID      = 4'd1,
    PM_POSFS    = 4'd2,
    PM_NEGFS    = 4'd3,
    PM_CHECKER  = 4'd4,
    PM_PN_LONG  = 4'd5,
    PM_PN_SHORT = 4'd6,
    PM_ONEZERO  = 4'd7,
    PM_USER     = 4'd8,
    PM_BITTOG   = 4'd9,
    PM_SYNC     = 4'd10,
    PM_ONEHI    = 4'd11,
    PM_MIXED    = 4'd12
  } pat_mode_e;

  function automatic logic is_pn(input logic [MODE_W-1:0] m);
    return (m == PM_PN_LONG) || (m == PM_PN_SHORT);
  endfunction

  function automatic logic format_subject(input logic [MODE_W-1:0] m);
    return (m == PM_MID) || (m == PM_POSFS) || (m == PM_NEGFS) || is_pn(m);
  endfunction

  // Fixed words; second_word picks the alternate word of a two-word pattern.
  function automatic logic [WORD_W-1:0] fixed_word(input logic [MODE_W-1:0] m,
                                                   input logic second_word,
                                                   input logic short_form);
    logic [WORD_W-1:0] w;
    w = '0;
    case (m)
      PM_MID, PM_ONEHI: w = short_form ? 14'h0800 : 14'h2000;
      PM_POSFS:         w = short_form ? 14'h0FFF : 14'h3FFF;
      PM_CHECKER: begin
        if (short_form) w = second_word ? 14'h0555 : 14'h0AAA;
        else            w = second_word ? 14'h1555 : 14'h2AAA;
      end
      PM_ONEZERO:       w = second_word ? 14'h0000 : (short_form ? 14'h0FFF : 14'h3FFF);
      PM_BITTOG:        w = short_form ? 14'h0AAA : 14'h2AAA;
      PM_SYNC:          w = short_form ? 14'h003F : 14'h007F;
      PM_MIXED:         w = short_form ? 14'h0A33 : 14'h2867;
      default:          w = '0;
    endcase
    return w;
  endfunction

  // Offset binary to two's complement: invert the sign bit of the word in use.
  function automatic logic [WORD_W-1:0] apply_format(input logic [WORD_W-1:0] w,
                                                     input logic twos,
                                                     input logic narrow);
    logic [WORD_W-1:0] r;
    r = w;
    if (twos) begin
      if (narrow) r[SHORT_W-1] = ~r[SHORT_W-1];
      else        r[WORD_W-1]  = ~r[WORD_W-1];
    end
    return r;
  endfunction
endpackage

// File: rtl/tpg_pn_gen.sv
module tpg_pn_gen
  import tpg_pkg::*;
#(
  parameter int LEN = 9,
  parameter int TAP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  output logic [WORD_W-1:0] word
);
  localparam int FB_IDX = TAP - 1;

  logic [LEN-1:0] state;
  logic [LEN-1:0] start_state;
  logic [LEN-1:0] next_state;

  assign start_state = restart ? {LEN{1'b1}} : state;

  // state[LEN-1] holds the earliest unsent bit; taps x^LEN + x^TAP + 1.
  always_comb begin
    logic [LEN-1:0] s;
    s    = start_state;
    word = '0;
    for (int i = 0; i < WORD_W; i++) begin
      word[WORD_W-1-i] = s[LEN-1];
      s = {s[LEN-2:0], s[LEN-1] ^ s[FB_IDX]};
    end
    next_state = s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     state <= {LEN{1'b1}};
    else if (step)  state <= next_state;
  end
endmodule

// File: rtl/tpg_pattern_mux.sv
module tpg_pattern_mux
  import tpg_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic              second_word,
  input  logic              short_word,
  input  logic              twos_comp,
  input  logic [WORD_W-1:0] adc_data,
  input  logic [WORD_W-1:0] pn_short_word,
  input  logic [WORD_W-1:0] pn_long_word,
  input  logic [UREG_W-1:0] user1_hi,
  input  logic [UREG_W-1:0] user1_lo,
  input  logic [UREG_W-1:0] user2_hi,
  input  logic [UREG_W-1:0] user2_lo,
  output logic [WORD_W-1:0] word
);
  localparam int PAIR_W = 2 * UREG_W;

  logic [PAIR_W-1:0] user_pair;
  logic [WORD_W-1:0] raw;
  logic              narrow;
  logic              unused_user_bits;

  assign user_pair = second_word ? {user2_hi, user2_lo} : {user1_hi, user1_lo};
  assign unused_user_bits = ^user_pair[PAIR_W-WORD_W-1:0];
  assign narrow = short_word && !is_pn(mode);

  always_comb begin
    case (mode)
      PM_MID, PM_POSFS, PM_NEGFS, PM_CHECKER, PM_ONEZERO,
      PM_BITTOG, PM_SYNC, PM_ONEHI, PM_MIXED:
        raw = fixed_word(mode, second_word, short_word);
      PM_PN_LONG:  raw = pn_long_word;
      PM_PN_SHORT: raw = pn_short_word;
      PM_USER:
        raw = short_word ? {{(WORD_W-SHORT_W){1'b0}}, user_pair[PAIR_W-1 -: SHORT_W]}
                         : user_pair[PAIR_W-1 -: WORD_W];
      default:
        raw = short_word ? {{(WORD_W-SHORT_W){1'b0}}, adc_data[WORD_W-1 -: SHORT_W]}
                         : adc_data;
    endcase
    word = apply_format(raw, twos_comp && format_subject(mode), narrow);
  end
endmodule

// File: rtl/adc_test_pattern_gen.sv
module adc_test_pattern_gen
  import tpg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_stb,
  input  logic [MODE_W-1:0] mode,
  input  logic              twos_comp,
  input  logic              short_word,
  input  logic [WORD_W-1:0] adc_data,
  input  logic [UREG_W-1:0] user1_hi,
  input  logic [UREG_W-1:0] user1_lo,
  input  logic [UREG_W-1:0] user2_hi,
  input  logic [UREG_W-1:0] user2_lo,
  output logic [WORD_W-1:0] pat_word,
  output logic              pat_valid
);
  logic [MODE_W-1:0] last_mode;
  logic              phase;
  logic              mode_entered;
  logic              cur_phase;
  logic [WORD_W-1:0] pn_short_w;
  logic [WORD_W-1:0] pn_long_w;
  logic [WORD_W-1:0] next_word;

  assign mode_entered = sample_stb && (mode != last_mode);
  assign cur_phase    = mode_entered ? 1'b0 : phase;

  tpg_pn_gen #(.LEN(9), .TAP(5)) i_pn_short (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (sample_stb && (mode == PM_PN_SHORT)),
    .restart (mode_entered),
    .word    (pn_short_w)
  );

  tpg_pn_gen #(.LEN(23), .TAP(18)) i_pn_long (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (sample_stb && (mode == PM_PN_LONG)),
    .restart (mode_entered),
    .word    (pn_long_w)
  );

  tpg_pattern_mux i_mux (
    .mode          (mode),
    .second_word   (cur_phase),
    .short_word    (short_word),
    .twos_comp     (twos_comp),
    .adc_data      (adc_data),
    .pn_short_word (pn_short_w),
    .pn_long_word  (pn_long_w),
    .user1_hi      (user1_hi),
    .user1_lo      (user1_lo),
    .user2_hi      (user2_hi),
    .user2_lo      (user2_lo),
    .word          (next_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_mode <= '0;
      phase     <= 1'b0;
      pat_word  <= '0;
      pat_valid <= 1'b0;
    end else begin
      pat_valid <= sample_stb;
      if (sample_stb) begin
        last_mode <= mode;
        phase     <= ~cur_phase;
        pat_word  <= next_word;
      end
    end
  end
endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
  import tpg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sample_stb,
  input logic [MODE_W-1:0] mode,
  input logic              twos_comp,
  input logic              short_word,
  input logic [WORD_W-1:0] pat_word,
  input logic              pat_valid
);
  logic [MODE_W-1:0] seen_mode;
  logic              entering;

  always_ff @(posedge clk) begin
    if (!rst_n)          seen_mode <= '0;
    else if (sample_stb) seen_mode <= mode;
  end
  assign entering = sample_stb && (mode != seen_mode);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> pat_valid); // R1
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> !pat_valid); // R1
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> $stable(pat_word)); // R1
  AST_POS_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && mode == PM_POSFS && !twos_comp && !short_word) |=> pat_word == 14'h3FFF); // R3
  AST_PN9_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (entering && mode == PM_PN_SHORT && !twos_comp) |=> pat_word == 14'h3FE0); // R8
  AST_PN23_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (entering && mode == PM_PN_LONG && !twos_comp) |=> pat_word == 14'h3FFF); // R9
  AST_SHORT_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && short_word && !is_pn(mode)) |=> pat_word[13:12] == 2'b00); // R12
endmodule

bind adc_test_pattern_gen tpg_checker i_tpg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sample_stb (sample_stb),
  .mode       (mode),
  .twos_comp  (twos_comp),
  .short_word (short_word),
  .pat_word   (pat_word),
  .pat_valid  (pat_valid)
);

// File: tb/test_adc_test_pattern_gen.sv
module test_adc_test_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_stb = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic        twos_comp = 1'b0;
  logic        short_word = 1'b0;
  logic [13:0] adc_data = 14'd0;
  logic [7:0]  user1_hi = 8'hC3, user1_lo = 8'h5A, user2_hi = 8'h3C, user2_lo = 8'hA5;
  logic [13:0] pat_word;
  logic        pat_valid;

  always #2 clk = ~clk;

  adc_test_pattern_gen i_adc_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .mode(mode),
    .twos_comp(twos_comp), .short_word(short_word), .adc_data(adc_data),
    .user1_hi(user1_hi), .user1_lo(user1_lo), .user2_hi(user2_hi), .user2_lo(user2_lo),
    .pat_word(pat_word), .pat_valid(pat_valid)
  );

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference model state
  logic [13:0] exp_word = '0;
  logic        exp_valid = 1'b0;
  int          m_last = 0;
  int          m_second = 0;
  int          m_mode = 0;
  bit          m_twos = 0;
  bit          q9[$];
  bit          q23[$];

  function automatic string req_of(int md, bit tw);
    if (tw && (md inside {1, 2, 3, 5, 6})) return "R4";
    case (md)
      1, 2, 3: return "R3";
      4, 7:    return "R5";
      5:       return "R9";
      6:       return "R8";
      8:       return "R7";
      9, 10, 11, 12: return "R6";
      default: return "R2";
    endcase
  endfunction

  task automatic pn_take(ref bit q[$], input int n, input int m, output logic [13:0] w);
    w = '0;
    for (int i = 0; i < 14; i++) begin
      bit b;
      b = q[0];
      q.push_back(q[0] ^ q[n - m]);
      void'(q.pop_front());
      w = {w[12:0], b};
    end
  endtask

  function automatic logic [13:0] model_word(int md, int sec, bit sh, logic [13:0] d);
    logic [15:0] u;
    case (md)
      1, 11: return sh ? 14'b1000_0000_0000 : 14'b10_0000_0000_0000;
      2:     return sh ? 14'b1111_1111_1111 : 14'b11_1111_1111_1111;
      3:     return 14'd0;
      4:     if (sec == 0) return sh ? 14'b1010_1010_1010 : 14'b10_1010_1010_1010;
             else          return sh ? 14'b0101_0101_0101 : 14'b01_0101_0101_0101;
      7:     return (sec == 0) ? (sh ? 14'hFFF : 14'h3FFF) : 14'd0;
      8: begin
        u = (sec == 0) ? {user1_hi, user1_lo} : {user2_hi, user2_lo};
        return sh ? {2'b00, u[15:4]} : u[15:2];
      end
      9:     return sh ? 14'b1010_1010_1010 : 14'b10_1010_1010_1010;
      10:    return sh ? 14'b0000_0011_1111 : 14'b00_0000_0111_1111;
      12:    return sh ? 14'b1010_0011_0011 : 14'b10_1000_0110_0111;
      default: return sh ? {2'b00, d[13:2]} : d;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_word = '0; exp_valid = 0; m_last = 0; m_second = 0;
    end else begin
      exp_valid = sample_stb;
      if (sample_stb) begin
        int md;
        logic [13:0] w;
        md = int'(mode);
        if (md != m_last) begin
          m_second = 0;
          if (md == 6) begin q9.delete();  for (int i = 0; i < 9;  i++) q9.push_back(1'b1);  end
          if (md == 5) begin q23.delete(); for (int i = 0; i < 23; i++) q23.push_back(1'b1); end
        end
        if (md == 6)      pn_take(q9, 9, 5, w);
        else if (md == 5) pn_take(q23, 23, 18, w);
        else              w = model_word(md, m_second, short_word, adc_data);
        if (twos_comp && (md inside {1, 2, 3, 5, 6})) begin
          if (md == 5 || md == 6 || !short_word) w[13] = ~w[13];
          else w[11] = ~w[11];
        end
        exp_word = w;
        m_second = 1 - m_second;
        m_last = md;
        m_mode = md;
        m_twos = twos_comp;
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (pat_valid !== exp_valid) begin
        miscompares++;
        $display("FAIL R1 pat_valid actual=%0b expected=%0b", pat_valid, exp_valid);
      end else if (pat_word !== exp_word) begin
        miscompares++;
        $display("FAIL %s mode=%0d pat_word actual=%h expected=%h",
                 req_of(m_mode, m_twos), m_mode, pat_word, exp_word);
      end
    end
  end

  task automatic chk(string req, logic [13:0] act, logic [13:0] expv);
    vectors++;
    if (act !== expv) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic one_strobe(int md, bit sh, bit tw);
    @(negedge clk);
    mode <= 4'(md); short_word <= sh; twos_comp <= tw;
    adc_data <= 14'($urandom); sample_stb <= 1'b1;
    @(negedge clk);
    sample_stb <= 1'b0;
  endtask

  task automatic run(int md, bit sh, bit tw, int count, bit gap);
    for (int i = 0; i < count; i++) begin
      @(negedge clk);
      mode <= 4'(md); short_word <= sh; twos_comp <= tw;
      adc_data <= 14'($urandom); sample_stb <= 1'b1;
      if (gap) begin
        @(negedge clk);
        sample_stb <= 1'b0;
      end
    end
    @(negedge clk);
    sample_stb <= 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13: reset state
    chk("R13", pat_word, 14'd0);
    chk("R13", {13'd0, pat_valid}, 14'd0);
    @(negedge clk);
    rst_n <= 1'b1;
    @(negedge clk);

    // R8 / R10: PN9 first word in short form stays full width
    one_strobe(6, 1'b1, 1'b0);
    chk("R10", pat_word, 14'h3FE0);
    // R1: idle cycle holds the word and drops valid
    @(negedge clk);
    chk("R1", {13'd0, pat_valid}, 14'd0);
    chk("R1", pat_word, 14'h3FE0);

    // R12: short form upper bits clear
    one_strobe(9, 1'b1, 1'b0);
    chk("R12", pat_word, 14'h0AAA);

    // R11: alternation restarts on mode change
    one_strobe(4, 1'b0, 1'b0);
    chk("R5", pat_word, 14'h2AAA);
    one_strobe(4, 1'b0, 1'b0);
    chk("R5", pat_word, 14'h1555);
    one_strobe(7, 1'b0, 1'b0);
    chk("R11", pat_word, 14'h3FFF);
    one_strobe(4, 1'b0, 1'b0);
    chk("R11", pat_word, 14'h2AAA);

    // R4: format applies to midscale, not to one-bit-high
    one_strobe(1, 1'b0, 1'b1);
    chk("R4", pat_word, 14'h0000);
    one_strobe(11, 1'b0, 1'b1);
    chk("R4", pat_word, 14'h2000);
    one_strobe(1, 1'b1, 1'b1);
    chk("R4", pat_word, 14'h0000);

    // R7: user word one then two
    one_strobe(8, 1'b0, 1'b0);
    chk("R7", pat_word, 14'h30D6);
    one_strobe(8, 1'b0, 1'b0);
    chk("R7", pat_word, 14'h0F29);

    // Sweep every code, both widths, both formats, with and without gaps (R2, R3, R5, R6, R9)
    for (int md = 0; md < 16; md++) begin
      for (int f = 0; f < 4; f++) begin
        run(md, f[0], f[1], 5, f[0] ^ f[1]);
      end
    end
    // Long PN runs
    run(5, 1'b0, 1'b0, 40, 1'b0);
    run(6, 1'b0, 1'b1, 40, 1'b1);
    run(5, 1'b1, 1'b1, 20, 1'b1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule